// File: doc/BRIEF.md
# Time-of-Day Counter with Per-Field Alarm

This block keeps time of day as four cascaded counters: a fraction-of-second field running at 256 steps per second, then seconds, minutes and hours. A prescaler divides the system clock down to the fraction step. Every step is one alarm evaluation. At each step the value the counters move to is compared with four alarm registers. Each field has its own compare enable, and a disabled field is treated as don't-care. When every enabled field agrees, a sticky alarm flag is set. That flag drives the interrupt output.

Software reaches the control word, the four time fields and the four alarm fields through a small synchronous register port. The control word holds the four compare enables, a read gate and a write gate for the time fields, the alarm flag, and the run bit. An ordinary reset leaves the compare enables, the time and the alarms as they were. A separate cold-reset input clears everything, to model loss of all power.

Because the alarm is evaluated at every step, leaving the fine fields disabled makes the alarm repeat. It fires again on each step of the finest disabled field for as long as the enabled coarse fields still match.

Top module: `rtc_alarm`

## Requirements
- R1: While run (control bit 0) is 1, the fraction field advances once every DIV clocks and wraps from 255 to 0. The first step comes on the DIV-th rising edge after the run bit is registered or after the last time-field write.
- R2: Seconds and minutes wrap from 59 to 0 and hours wrap from 23 to 0. A wrap carries into the next field on the same step.
- R3: Register addresses are: 0 control, 1 to 4 time (fraction, seconds, minutes, hours), 5 to 8 alarm in the same field order. In the control word, bit 7 enables fraction compare, bit 6 seconds, bit 5 minutes, bit 4 hours, bit 3 is the time read gate, bit 2 the time write gate, bit 1 the alarm flag and bit 0 run.
- R4: On a step, the flag is set when every enabled field of the new time equals its alarm field. A disabled field does not affect the result.
- R5: With all four compare enables at 0, the flag is never set.
- R6: The match is evaluated again on every step, so the flag is set again on each step for as long as the enabled fields keep matching.
- R7: The flag stays set until a control write with bit 1 equal to 0. Writing 1 to bit 1 does not set it. A match in the same cycle as a clearing write wins.
- R8: With run at 0, the time fields hold their values.
- R9: A time-field write loads the field only while the write gate is 1 and also clears the prescaler. A write with the gate at 0 is ignored.
- R10: A read of a time field returns its value only while the read gate is 1 and returns 0 otherwise. Read data appears on the clock edge after the read request.
- R11: Ordinary reset clears control bits 3 to 0 and the prescaler. It keeps the compare enables, the time fields and the alarm fields.
- R12: Cold reset clears the control word, the time fields and the alarm fields.
- R13: irq equals the alarm flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Ordinary synchronous reset, active high |
| cold_rst | input | 1 | Power-loss synchronous reset, active high, clears all state |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Alarm interrupt request, equal to the sticky flag |

## Verification
The match logic is driven with several enable masks: a single coarse field, fraction plus seconds, three fields across a seconds-to-minutes carry, all four fields across the midnight wrap, seconds only after a fraction carry, and no field at all. A mask that includes the fraction field separates an exact match from a near miss one step early. A mask that leaves the fraction field out shows the repeat on every step. The carry cases show that the alarm compares against the value being entered and not the value being left. Directed runs then separate the two resets from each other and check the two gates and the hold with run at 0.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NF = 4;   // fields: 0 fraction, 1 sec, 2 min, 3 hour
  localparam int FW = 8;   // field and bus width

  typedef logic [NF-1:0][FW-1:0] rtc_time_t;

  // control word bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_FLAG = 1;
  localparam int CB_WE   = 2;
  localparam int CB_RE   = 3;
  localparam int CB_EN   = 7;  // enable of field i sits at bit CB_EN - i

  // address map
  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_TIME = 4'd1;
  localparam logic [3:0] A_ALM  = 4'd5;

  function automatic logic [FW-1:0] field_max(input int idx);
    case (idx)
      0:       return 8'd255;
      1, 2:    return 8'd59;
      default: return 8'd23;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST) && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (run)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_chk
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R1
    end
  endgenerate
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic          clk,
  input  logic          cold_rst,
  input  logic          tick,
  input  logic          wr,
  input  logic [1:0]    wr_idx,
  input  logic [FW-1:0] wr_data,
  output rtc_time_t     time_q,
  output rtc_time_t     time_nxt
);
  logic [NF-1:0] carry;
  logic [NF-1:0] wrap;

  assign carry[0] = tick;

  genvar i;
  generate
    for (i = 0; i < NF; i++) begin : g_field
      assign wrap[i]     = time_q[i] >= field_max(i);
      assign time_nxt[i] = carry[i] ? (wrap[i] ? '0 : time_q[i] + 8'd1) : time_q[i];
      if (i < NF - 1) begin : g_carry
        assign carry[i+1] = carry[i] && wrap[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      time_q <= '0;
    end else begin
      for (int k = 0; k < NF; k++) begin
        if (wr && wr_idx == 2'(k)) time_q[k] <= wr_data;
        else                       time_q[k] <= time_nxt[k];
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (cold_rst)
    (!tick && !wr) |=> $stable(time_q)); // R8

  AST_FRAC_WRAP: assert property (@(posedge clk) disable iff (cold_rst)
    (tick && !wr && time_q[0] == 8'd255) |=> (time_q[0] == 8'd0)); // R1
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_pkg::*;
(
  input  logic [NF-1:0] en,
  input  rtc_time_t     alarm,
  input  rtc_time_t     cand,
  output logic          match
);
  logic [NF-1:0] ok;

  genvar i;
  generate
    for (i = 0; i < NF; i++) begin : g_cmp
      assign ok[i] = !en[i] || (cand[i] == alarm[i]);
    end
  endgenerate

  assign match = (|en) && (&ok);
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cold_rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  logic [NF-1:0] en_q;
  logic          re_q, we_q, flag_q, run_q;
  rtc_time_t     alarm_q, time_q, time_nxt;
  logic          tick, match;

  wire is_time = (bus_addr >= A_TIME) && (bus_addr < A_ALM);
  wire is_alm  = (bus_addr >= A_ALM) && (bus_addr < A_ALM + 4'(NF));
  wire ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  wire time_wr = bus_wr && we_q && is_time;
  wire [1:0] t_idx = 2'(bus_addr - A_TIME);
  wire [1:0] a_idx = 2'(bus_addr - A_ALM);

  logic [7:0] ctrl_word;
  always_comb begin
    ctrl_word = '0;
    for (int k = 0; k < NF; k++) ctrl_word[CB_EN-k] = en_q[k];
    ctrl_word[CB_RE]   = re_q;
    ctrl_word[CB_WE]   = we_q;
    ctrl_word[CB_FLAG] = flag_q;
    ctrl_word[CB_RUN]  = run_q;
  end

  rtc_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst || cold_rst), .clr(time_wr), .run(run_q), .tick(tick)
  );

  rtc_time_chain u_chain (
    .clk(clk), .cold_rst(cold_rst), .tick(tick), .wr(time_wr),
    .wr_idx(t_idx), .wr_data(bus_wdata), .time_q(time_q), .time_nxt(time_nxt)
  );

  rtc_alarm_cmp u_cmp (
    .en(en_q), .alarm(alarm_q), .cand(time_nxt), .match(match)
  );

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      en_q <= '0; re_q <= 1'b0; we_q <= 1'b0; flag_q <= 1'b0; run_q <= 1'b0;
      alarm_q <= '0;
    end else if (rst) begin
      re_q <= 1'b0; we_q <= 1'b0; flag_q <= 1'b0; run_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        for (int k = 0; k < NF; k++) en_q[k] <= bus_wdata[CB_EN-k];
        re_q  <= bus_wdata[CB_RE];
        we_q  <= bus_wdata[CB_WE];
        run_q <= bus_wdata[CB_RUN];
      end
      if (bus_wr && is_alm) alarm_q[a_idx] <= bus_wdata;
      flag_q <= (ctrl_wr ? (flag_q && bus_wdata[CB_FLAG]) : flag_q) || (tick && match);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cold_rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == A_CTRL) bus_rdata <= ctrl_word;
      else if (is_time)       bus_rdata <= re_q ? time_q[t_idx] : '0;
      else if (is_alm)        bus_rdata <= alarm_q[a_idx];
      else                    bus_rdata <= '0;
    end
  end

  assign irq = flag_q;

  AST_NO_EN_NO_SET: assert property (@(posedge clk) disable iff (rst || cold_rst)
    (en_q == '0 && !flag_q) |=> !flag_q); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst || cold_rst)
    (flag_q && !ctrl_wr) |=> flag_q); // R7

  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (rst || cold_rst)
    (tick && match) |=> flag_q); // R4

  AST_WR_GATED: assert property (@(posedge clk) disable iff (cold_rst)
    (bus_wr && is_time && !we_q && !tick) |=> $stable(time_q)); // R9
endmodule

// File: tb/rtc_alarm_test.sv
module rtc_alarm_test;
  localparam int CLK = 10;
  localparam int DIV = 4;
  localparam int NV  = 8;

  logic clk = 1'b0, rst = 1'b1, cold_rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq;
  int checks = 0, fails = 0;

  always #(CLK/2) clk = ~clk;

  rtc_alarm #(.DIV(DIV)) uut (
    .clk(clk), .rst(rst), .cold_rst(cold_rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {enables, alarm hr,min,sec,frac, start hr,min,sec,frac, steps, expected irq}
  localparam logic [87:0] VEC [NV] = '{
    {8'h10, 8'd5, 8'd0, 8'd0,  8'd0,   8'd5,  8'd0,  8'd0,  8'd0,   8'd1, 8'd1}, // R4 hour only
    {8'hC0, 8'd0, 8'd0, 8'd10, 8'd3,   8'd0,  8'd0,  8'd10, 8'd0,   8'd2, 8'd0}, // R4 one step early
    {8'hC0, 8'd0, 8'd0, 8'd10, 8'd3,   8'd0,  8'd0,  8'd10, 8'd0,   8'd3, 8'd1}, // R4 exact
    {8'h00, 8'd0, 8'd0, 8'd0,  8'd3,   8'd0,  8'd0,  8'd0,  8'd0,   8'd5, 8'd0}, // R5
    {8'hE0, 8'd0, 8'd1, 8'd0,  8'd0,   8'd0,  8'd0,  8'd59, 8'd254, 8'd2, 8'd1}, // R2 carry
    {8'hF0, 8'd0, 8'd0, 8'd0,  8'd0,   8'd23, 8'd59, 8'd59, 8'd255, 8'd1, 8'd1}, // R2 midnight
    {8'h10, 8'd6, 8'd0, 8'd0,  8'd0,   8'd5,  8'd0,  8'd0,  8'd0,   8'd3, 8'd0}, // R4 mismatch
    {8'h40, 8'd0, 8'd0, 8'd0,  8'd0,   8'd0,  8'd0,  8'd59, 8'd255, 8'd1, 8'd1}  // R2 frac carry
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic steps(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  initial begin
    #(CLK * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    repeat (3) @(negedge clk);
    rst = 1'b0; cold_rst = 1'b0;
    check(irq == 1'b0, "R12 irq after reset", irq, 0);
    rd(4'd0, v); check(v == 8'h00, "R12 ctrl after reset", v, 0);

    // table of alarm cases
    for (int n = 0; n < NV; n++) begin
      wr(4'd0, VEC[n][87:80] | 8'h0C);
      wr(4'd8, VEC[n][79:72]); wr(4'd7, VEC[n][71:64]);
      wr(4'd6, VEC[n][63:56]); wr(4'd5, VEC[n][55:48]);
      wr(4'd4, VEC[n][47:40]); wr(4'd3, VEC[n][39:32]);
      wr(4'd2, VEC[n][31:24]); wr(4'd1, VEC[n][23:16]);
      wr(4'd0, VEC[n][87:80] | 8'h0D);
      steps(int'(VEC[n][15:8]));
      check(irq == VEC[n][0], $sformatf("R4 vector %0d", n), irq, int'(VEC[n][0]));
    end

    // R1 R2: counting after a load, then stop
    wr(4'd0, 8'h0C); wr(4'd2, 8'd0); wr(4'd1, 8'd10);
    wr(4'd0, 8'h0D); steps(3); wr(4'd0, 8'h0C);
    rd(4'd1, v); check(v == 8'd13, "R1 frac after 3 steps", v, 13);

    // R6: hour-only match repeats each step; R7 clear
    wr(4'd8, 8'd5); wr(4'd4, 8'd5); wr(4'd1, 8'd0);
    wr(4'd0, 8'h1D); steps(1);
    check(irq == 1'b1, "R6 first match", irq, 1);
    wr(4'd0, 8'h1D);
    check(irq == 1'b0, "R7 cleared by write 0", irq, 0);
    repeat (DIV - 1) @(negedge clk);
    check(irq == 1'b1, "R6 set again next step", irq, 1);

    // R7 sticky and write-1 has no effect
    wr(4'd0, 8'h8C); wr(4'd5, 8'd2); wr(4'd1, 8'd0);
    wr(4'd0, 8'h8D); steps(2);
    check(irq == 1'b1, "R7 frac exact match", irq, 1);
    steps(3);
    check(irq == 1'b1, "R7 sticky after mismatch", irq, 1);
    wr(4'd0, 8'h0C);
    check(irq == 1'b0, "R7 clear", irq, 0);
    wr(4'd0, 8'h0E);
    check(irq == 1'b0, "R7 write 1 ignored", irq, 0);
    rd(4'd0, v); check(v == 8'h0C, "R3 ctrl readback", v, 8'h0C);

    // R8 hold while stopped
    wr(4'd1, 8'd100); wr(4'd0, 8'h0D); steps(2); wr(4'd0, 8'h0C);
    rd(4'd1, v); repeat (40) @(negedge clk); rd(4'd1, v2);
    check(v2 == v, "R8 hold while stopped", v2, v);

    // R9 R10 gates
    wr(4'd0, 8'h04); wr(4'd2, 8'd33);
    rd(4'd2, v); check(v == 8'd0, "R10 read gate closed", v, 0);
    wr(4'd0, 8'h08); rd(4'd2, v); check(v == 8'd33, "R9 gated write loads", v, 33);
    wr(4'd2, 8'd7); rd(4'd2, v); check(v == 8'd33, "R9 write ignored", v, 33);

    // R11 ordinary reset
    wr(4'd0, 8'hF4); wr(4'd2, 8'd42); wr(4'd6, 8'd17); wr(4'd0, 8'hFD);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    rd(4'd0, v); check(v == 8'hF0, "R11 ctrl after rst", v, 8'hF0);
    wr(4'd0, 8'hF8); rd(4'd2, v); check(v == 8'd42, "R11 time kept", v, 42);
    rd(4'd6, v); check(v == 8'd17, "R11 alarm kept", v, 17);

    // R12 cold reset
    @(negedge clk); cold_rst = 1'b1; @(negedge clk); cold_rst = 1'b0;
    rd(4'd0, v); check(v == 8'h00, "R12 ctrl cleared", v, 0);
    wr(4'd0, 8'h08); rd(4'd2, v); check(v == 8'd0, "R12 time cleared", v, 0);
    rd(4'd6, v); check(v == 8'd0, "R12 alarm cleared", v, 0);
    check(irq == 1'b0, "R13 irq low", irq, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule